// File: doc/BRIEF.md
# External-Master DRAM Strobe Sequencer

This block lets a bus master outside the chip reach an asynchronous DRAM bank without page mode. When the master signals the start of a transfer and the address decodes to DRAM, the block captures the address. It presents that address on a shared address output, first as the row field and then as the column field. It places the row strobe, column strobe and write strobe on half-cycle boundaries. It also runs a three-state transfer-acknowledge back to the master. The data path belongs to the master and the DRAM, and the block does not touch it.

Half-cycle events are timed from a clock `clk2x` that runs at twice the bus rate. An internal phase bit marks every other `clk2x` edge as a bus-clock rising edge. The edges in between are falling edges. Each three-state output is shown as a value plus an output-enable.

An operand wider than the bank port becomes a burst. The master issues one start, and the block splits the burst into port-wide beats, stepping the address by the port width each time. Before each later beat it waits out a programmable row-precharge time.

Top module: `dramc_xm_ctrl`

## Requirements
- R1: While `rst` is high and afterwards in idle: `addr_oe`=0, `ras_n`=1, `cas_n`=4'b1111, `dram_we_n`=1, `ack_n`=1, `ack_oe`=0. The first `clk2x` edge after `rst` falls is a bus rising edge, and the phases alternate from then on. A reset in mid-transfer returns every output to these values.
- R2: A transfer is accepted only at a bus rising edge where `xs_n`=0 and `dram_sel`=1. At that edge `addr_in`, `xfer_wr`, `xfer_size` and `port_size` are captured. A low `xs_n` on a falling edge, or with `dram_sel`=0, is ignored.
- R3: At the next bus rising edge `addr_oe`=1 and `addr_out` equals the beat address. At the same edge `dram_we_n`=0 for a write and stays 1 for a read.
- R4: `ras_n` goes low on the falling edge that follows.
- R5: On the next rising edge, bits 27..9 of `addr_out` take beat-address bits 18..0, and bits 8..0 are unchanged. At the same edge `ack_oe`=1 with `ack_n`=1.
- R6: On the following falling edge, `cas_n` is the inverse of the lane mask. The mask holds min(operand, port) bytes of ones, shifted by the address bits inside the port: none for an 8-bit port, bit 0 for a 16-bit port, bits 1..0 for a 32-bit port.
- R7: `ack_n` goes low on the next rising edge.
- R8: On the rising edge after that, the beat completes: `ras_n`=1, `cas_n`=4'b1111, `ack_n`=1, `addr_oe`=0 and `dram_we_n`=1. After the last beat, `ack_oe` returns to 0 one rising edge later.
- R9: Size encodings: `xfer_size` 00 byte, 01 word, 10 longword, 11 16-byte line; `port_size` 00 8-bit, 01 16-bit, 10 32-bit. The beat count is max(1, operand bytes / port bytes), and each beat's address is the previous one plus the port width in bytes.
- R10: With P = `cfg_precharge`+1 bus clocks, the next beat's row address appears P rising edges after a non-final completion. `ras_n` stays high until then, and `ack_oe` stays 1 through the gap.
- R11: A start that arrives while a transfer is in progress is ignored, and the block returns to idle after the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; its edges alternate between bus rising and falling edges |
| rst | input | 1 | Synchronous active-high reset |
| cfg_precharge | input | 2 | Row precharge time between beats, in bus clocks minus one |
| xs_n | input | 1 | Transfer start from the master, active low |
| dram_sel | input | 1 | Address decodes to the DRAM bank |
| xfer_wr | input | 1 | 1 = write, 0 = read |
| xfer_size | input | 2 | Operand size encoding |
| port_size | input | 2 | Bank port width encoding |
| addr_in | input | 28 | Address from the master |
| addr_out | output | 28 | Row and then column address to the DRAM |
| addr_oe | output | 1 | Drive enable for `addr_out` |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 4 | Column strobes per byte lane, active low |
| dram_we_n | output | 1 | DRAM write strobe, active low |
| ack_n | output | 1 | Transfer acknowledge value, active low |
| ack_oe | output | 1 | Drive enable for the acknowledge |

## Verification
The hardest state to reach from the ports is the gap between secondary beats of a burst. There the acknowledge is still driven while the row strobe is high, and the next row address must appear on exactly the P-th rising edge. The vector table therefore covers line and longword operands on 8-, 16- and 32-bit ports, with every precharge setting. For each gap edge the bench checks that the row strobe and address enable stay idle, and then that the row address appears on exactly the predicted edge. Directed cases then pulse a start during a busy burst, offer a start on a falling edge, and reset while the row strobe is low.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    OP_BYTE = 2'b00,
    OP_WORD = 2'b01,
    OP_LONG = 2'b10,
    OP_LINE = 2'b11
  } op_size_e;

  function automatic logic [2:0] op_log2(input logic [1:0] s);
    case (s)
      2'b00:   return 3'd0;
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] port_log2(input logic [1:0] p);
    return (p == 2'b11) ? 3'd2 : {1'b0, p};
  endfunction

  function automatic logic [4:0] beat_count(input logic [1:0] s, input logic [1:0] p);
    logic [2:0] ol;
    logic [2:0] pl;
    ol = op_log2(s);
    pl = port_log2(p);
    if (ol > pl) return 5'd1 << (ol - pl);
    return 5'd1;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] s, input logic [1:0] p,
                                                 input logic [1:0] a_lo);
    logic [2:0] ol;
    logic [2:0] pl;
    logic [2:0] wl;
    logic [4:0] m;
    logic [1:0] off;
    ol = op_log2(s);
    pl = port_log2(p);
    wl = (ol < pl) ? ol : pl;
    m  = (5'd1 << (3'd1 << wl)) - 5'd1;
    case (pl)
      3'd0:    off = 2'd0;
      3'd1:    off = {1'b0, a_lo[0]};
      default: off = a_lo;
    endcase
    return LANES'(m << off);
  endfunction

endpackage

// File: rtl/dramc_phase.sv
module dramc_phase (
  input  logic clk2x,
  input  logic rst,
  output logic rise
);
  logic ph;

  always_ff @(posedge clk2x) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  assign rise = ~ph;
endmodule

// File: rtl/dramc_beat.sv
module dramc_beat
  import dramc_pkg::*;
#(
  parameter int AW = 28
) (
  input  logic             clk2x,
  input  logic             rst,
  input  logic             load,
  input  logic             advance,
  input  logic [AW-1:0]    addr_in,
  input  logic [1:0]       size_in,
  input  logic [1:0]       port_in,
  input  logic [1:0]       cfg_pre,
  output logic [AW-1:0]    cur_addr,
  output logic             last_beat,
  output logic [LANES-1:0] lanes,
  output logic [2:0]       pre_half
);
  logic [4:0] beats_left;
  logic [1:0] size_q;
  logic [1:0] port_q;

  always_ff @(posedge clk2x) begin
    if (rst) begin
      cur_addr   <= '0;
      beats_left <= 5'd0;
      size_q     <= 2'b00;
      port_q     <= 2'b00;
      pre_half   <= 3'd1;
    end else if (load) begin
      cur_addr   <= addr_in;
      beats_left <= beat_count(size_in, port_in);
      size_q     <= size_in;
      port_q     <= port_in;
      pre_half   <= {cfg_pre, 1'b1};
    end else if (advance) begin
      cur_addr   <= cur_addr + (AW'(1) << port_log2(port_q));
      beats_left <= beats_left - 5'd1;
    end
  end

  assign last_beat = (beats_left == 5'd1);
  assign lanes     = lane_mask(size_q, port_q, cur_addr[1:0]);
endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int AW      = 28,
  parameter int ROW_LSB = 9
) (
  input  logic             clk2x,
  input  logic             rst,
  input  logic             rise,
  input  logic             xs_n,
  input  logic             dram_sel,
  input  logic             wr_in,
  input  logic [AW-1:0]    cur_addr,
  input  logic             last_beat,
  input  logic [LANES-1:0] lanes,
  input  logic [2:0]       pre_half,
  output logic             load,
  output logic             advance,
  output logic [AW-1:0]    addr_out,
  output logic             addr_oe,
  output logic             ras_n,
  output logic [LANES-1:0] cas_n,
  output logic             dram_we_n,
  output logic             ack_n,
  output logic             ack_oe
);
  localparam int COLW = AW - ROW_LSB;

  logic       busy;
  logic [3:0] step;
  logic [2:0] hold;
  logic       wr_q;
  logic       active;

  assign load    = !busy && rise && !xs_n && dram_sel;
  assign active  = busy && (hold == 3'd0);
  assign advance = active && (step == 4'd8) && !last_beat;

  always_ff @(posedge clk2x) begin
    if (rst) begin
      busy      <= 1'b0;
      step      <= 4'd0;
      hold      <= 3'd0;
      wr_q      <= 1'b0;
      addr_out  <= '0;
      addr_oe   <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= '1;
      dram_we_n <= 1'b1;
      ack_n     <= 1'b1;
      ack_oe    <= 1'b0;
    end else if (load) begin
      busy <= 1'b1;
      step <= 4'd1;
      wr_q <= wr_in;
    end else if (busy) begin
      if (hold != 3'd0) begin
        hold <= hold - 3'd1;
      end else begin
        case (step)
          4'd2: begin
            addr_oe   <= 1'b1;
            addr_out  <= cur_addr;
            dram_we_n <= ~wr_q;
            step      <= 4'd3;
          end
          4'd3: begin
            ras_n <= 1'b0;
            step  <= 4'd4;
          end
          4'd4: begin
            addr_out[AW-1:ROW_LSB] <= cur_addr[COLW-1:0];
            ack_oe <= 1'b1;
            ack_n  <= 1'b1;
            step   <= 4'd5;
          end
          4'd5: begin
            cas_n <= ~lanes;
            step  <= 4'd6;
          end
          4'd6: begin
            ack_n <= 1'b0;
            step  <= 4'd7;
          end
          4'd8: begin
            ras_n     <= 1'b1;
            cas_n     <= '1;
            ack_n     <= 1'b1;
            addr_oe   <= 1'b0;
            addr_out  <= '0;
            dram_we_n <= 1'b1;
            if (last_beat) begin
              step <= 4'd9;
            end else begin
              step <= 4'd2;
              hold <= pre_half;
            end
          end
          4'd10: begin
            ack_oe <= 1'b0;
            busy   <= 1'b0;
            step   <= 4'd0;
          end
          default: step <= step + 4'd1;
        endcase
      end
    end
  end

  // Checker state: bus half-cycles with the row strobe high, and a flag for
  // the gap between beats of one burst.
  logic [3:0] hi_cnt;
  logic       burst_gap;

  always_ff @(posedge clk2x) begin
    if (rst) begin
      hi_cnt    <= 4'd0;
      burst_gap <= 1'b0;
    end else begin
      if (!ras_n)               hi_cnt <= 4'd0;
      else if (hi_cnt != 4'hF)  hi_cnt <= hi_cnt + 4'd1;
      if (advance)                           burst_gap <= 1'b1;
      else if (active && step == 4'd4)       burst_gap <= 1'b0;
    end
  end

  // R10: row strobe high for at least the programmed precharge between beats
  a_r10_precharge_gap: assert property (@(posedge clk2x) disable iff (rst)
    ($fell(ras_n) && burst_gap) |-> (hi_cnt >= (4'(pre_half) + 4'd2)));

  // R11: no new capture while a transfer is running
  a_r11_no_reload: assert property (@(posedge clk2x) disable iff (rst)
    (addr_oe || !ras_n) |-> !load);
endmodule

// File: rtl/dramc_xm_ctrl.sv
module dramc_xm_ctrl
  import dramc_pkg::*;
#(
  parameter int AW      = 28,
  parameter int ROW_LSB = 9
) (
  input  logic             clk2x,
  input  logic             rst,
  input  logic [1:0]       cfg_precharge,
  input  logic             xs_n,
  input  logic             dram_sel,
  input  logic             xfer_wr,
  input  logic [1:0]       xfer_size,
  input  logic [1:0]       port_size,
  input  logic [AW-1:0]    addr_in,
  output logic [AW-1:0]    addr_out,
  output logic             addr_oe,
  output logic             ras_n,
  output logic [LANES-1:0] cas_n,
  output logic             dram_we_n,
  output logic             ack_n,
  output logic             ack_oe
);
  logic             rise;
  logic             load;
  logic             advance;
  logic [AW-1:0]    cur_addr;
  logic             last_beat;
  logic [LANES-1:0] lanes;
  logic [2:0]       pre_half;

  dramc_phase u_phase (
    .clk2x (clk2x),
    .rst   (rst),
    .rise  (rise)
  );

  dramc_beat #(.AW(AW)) u_beat (
    .clk2x     (clk2x),
    .rst       (rst),
    .load      (load),
    .advance   (advance),
    .addr_in   (addr_in),
    .size_in   (xfer_size),
    .port_in   (port_size),
    .cfg_pre   (cfg_precharge),
    .cur_addr  (cur_addr),
    .last_beat (last_beat),
    .lanes     (lanes),
    .pre_half  (pre_half)
  );

  dramc_seq #(.AW(AW), .ROW_LSB(ROW_LSB)) u_seq (
    .clk2x     (clk2x),
    .rst       (rst),
    .rise      (rise),
    .xs_n      (xs_n),
    .dram_sel  (dram_sel),
    .wr_in     (xfer_wr),
    .cur_addr  (cur_addr),
    .last_beat (last_beat),
    .lanes     (lanes),
    .pre_half  (pre_half),
    .load      (load),
    .advance   (advance),
    .addr_out  (addr_out),
    .addr_oe   (addr_oe),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .dram_we_n (dram_we_n),
    .ack_n     (ack_n),
    .ack_oe    (ack_oe)
  );

  // R4: a column strobe is only active under an active row strobe
  a_r4_cas_under_ras: assert property (@(posedge clk2x) disable iff (rst)
    (cas_n != '1) |-> !ras_n);

  // R3: write strobe only while the address bus is driven
  a_r3_we_with_addr: assert property (@(posedge clk2x) disable iff (rst)
    !dram_we_n |-> addr_oe);

  // R7: acknowledge asserted only while driven
  a_r7_ack_driven: assert property (@(posedge clk2x) disable iff (rst)
    !ack_n |-> ack_oe);

  // R8: acknowledge released only after all strobes are negated
  a_r8_clean_release: assert property (@(posedge clk2x) disable iff (rst)
    $fell(ack_oe) |-> (ras_n && (cas_n == '1) && !addr_oe));

  // R5: row strobe active only with the address bus driven
  a_r5_addr_under_ras: assert property (@(posedge clk2x) disable iff (rst)
    !ras_n |-> addr_oe);
endmodule

// File: tb/test_dramc_xm_ctrl.sv
module test_dramc_xm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 28;

  typedef struct packed {
    logic          wr;
    logic [1:0]    sz;
    logic [1:0]    ps;
    logic [AW-1:0] a;
    logic [1:0]    pc;
    logic [4:0]    nb;
    logic [3:0]    mk;
  } vec_t;

  // wr, size, port, address, precharge cfg, expected beats, expected lane mask
  localparam vec_t VECS [0:9] = '{
    '{1'b1, 2'b00, 2'b10, 28'h12345_01, 2'd0, 5'd1, 4'b0010},
    '{1'b0, 2'b01, 2'b10, 28'h0ABCD_02, 2'd1, 5'd1, 4'b1100},
    '{1'b0, 2'b10, 2'b10, 28'h7F00E_00, 2'd0, 5'd1, 4'b1111},
    '{1'b1, 2'b11, 2'b10, 28'h05A5A_10, 2'd2, 5'd4, 4'b1111},
    '{1'b0, 2'b10, 2'b00, 28'h0C3C3_20, 2'd0, 5'd4, 4'b0001},
    '{1'b1, 2'b10, 2'b01, 28'h01234_04, 2'd3, 5'd2, 4'b0011},
    '{1'b0, 2'b00, 2'b01, 28'h0FEDC_07, 2'd0, 5'd1, 4'b0010},
    '{1'b1, 2'b11, 2'b01, 28'h03333_30, 2'd1, 5'd8, 4'b0011},
    '{1'b0, 2'b01, 2'b00, 28'h0AAAA_00, 2'd0, 5'd2, 4'b0001},
    '{1'b1, 2'b00, 2'b00, 28'h05555_03, 2'd3, 5'd1, 4'b0001}
  };

  logic          clk2x = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_precharge = 2'd0;
  logic          xs_n = 1'b1;
  logic          dram_sel = 1'b0;
  logic          xfer_wr = 1'b0;
  logic [1:0]    xfer_size = 2'b00;
  logic [1:0]    port_size = 2'b10;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          addr_oe;
  logic          ras_n;
  logic [3:0]    cas_n;
  logic          dram_we_n;
  logic          ack_n;
  logic          ack_oe;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  rise_next = 1'b1;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  dramc_xm_ctrl i_dramc_xm_ctrl (
    .clk2x(clk2x), .rst(rst), .cfg_precharge(cfg_precharge), .xs_n(xs_n),
    .dram_sel(dram_sel), .xfer_wr(xfer_wr), .xfer_size(xfer_size),
    .port_size(port_size), .addr_in(addr_in), .addr_out(addr_out),
    .addr_oe(addr_oe), .ras_n(ras_n), .cas_n(cas_n), .dram_we_n(dram_we_n),
    .ack_n(ack_n), .ack_oe(ack_oe)
  );

  task automatic step();
    @(posedge clk2x);
    #1;
    rise_next = ~rise_next;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "addr_oe", 32'(addr_oe), 32'd0);
    chk(req, "ras_n", 32'(ras_n), 32'd1);
    chk(req, "cas_n", 32'(cas_n), 32'hF);
    chk(req, "we_n", 32'(dram_we_n), 32'd1);
    chk(req, "ack_n", 32'(ack_n), 32'd1);
    chk(req, "ack_oe", 32'(ack_oe), 32'd0);
  endtask

  task automatic run_xfer(input vec_t v, input bit poke);
    logic [AW-1:0] cur;
    if (!rise_next) step();
    xs_n = 1'b0; dram_sel = 1'b1; xfer_wr = v.wr; xfer_size = v.sz;
    port_size = v.ps; addr_in = v.a; cfg_precharge = v.pc;
    step();                               // capture edge (R2)
    xs_n = poke ? 1'b0 : 1'b1;
    addr_in = ~v.a;
    xfer_wr = ~v.wr;
    step();                               // falling
    cur = v.a;
    for (int b = 0; b < int'(v.nb); b++) begin
      step();                             // row rising edge
      chk("R3", "addr_oe row", 32'(addr_oe), 32'd1);
      chk("R3", "row address", 32'(addr_out), 32'(cur));
      chk("R3", "we_n", 32'(dram_we_n), 32'(!v.wr));
      chk("R3", "ras_n before", 32'(ras_n), 32'd1);
      step();
      chk("R4", "ras_n low", 32'(ras_n), 32'd0);
      step();
      chk("R5", "column address", 32'(addr_out), 32'({cur[18:0], cur[8:0]}));
      chk("R5", "ack_oe", 32'(ack_oe), 32'd1);
      chk("R5", "ack_n negated", 32'(ack_n), 32'd1);
      chk("R5", "cas idle", 32'(cas_n), 32'hF);
      step();
      chk("R6", "cas lanes", 32'(cas_n), 32'(~v.mk & 4'hF));
      step();
      chk("R7", "ack_n low", 32'(ack_n), 32'd0);
      step();
      step();                             // completion edge
      if (b == int'(v.nb) - 1) xs_n = 1'b1;
      chk("R8", "ras_n", 32'(ras_n), 32'd1);
      chk("R8", "cas_n", 32'(cas_n), 32'hF);
      chk("R8", "ack_n", 32'(ack_n), 32'd1);
      chk("R8", "addr_oe", 32'(addr_oe), 32'd0);
      chk("R8", "we_n", 32'(dram_we_n), 32'd1);
      chk("R8", "ack_oe still", 32'(ack_oe), 32'd1);
      if (b != int'(v.nb) - 1) begin
        cur = cur + (AW'(1) << v.ps);      // R9 address step
        for (int k = 0; k < 2 * (int'(v.pc) + 1) - 1; k++) begin
          step();
          chk("R10", "ras_n gap", 32'(ras_n), 32'd1);
          chk("R10", "addr_oe gap", 32'(addr_oe), 32'd0);
          chk("R10", "ack_oe gap", 32'(ack_oe), 32'd1);
        end
      end
    end
    step();
    step();
    chk("R8", "ack_oe released", 32'(ack_oe), 32'd0);
    dram_sel = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk_idle("R1");                       // during reset
    rst = 1'b0;
    rise_next = 1'b1;
    step();
    chk_idle("R1");
    step();

    // vector table: R3..R10 with burst counts and lane masks (R9)
    for (int i = 0; i < 10; i++) begin
      run_xfer(VECS[i], 1'b0);
      chk("R9", "idle after vector", 32'(addr_oe), 32'd0);
    end

    // R2: start offered on a falling edge is ignored
    if (!rise_next) step();
    step();
    xs_n = 1'b0; dram_sel = 1'b1;
    step();
    xs_n = 1'b1;
    repeat (4) step();
    chk_idle("R2");

    // R2: start with DRAM select low is ignored
    if (!rise_next) step();
    xs_n = 1'b0; dram_sel = 1'b0;
    step();
    xs_n = 1'b1;
    repeat (4) step();
    chk_idle("R2");

    // R11: start held low during a whole burst is ignored
    run_xfer(VECS[3], 1'b1);
    step();
    step();
    chk_idle("R11");

    // R1: reset while the row strobe is active
    if (!rise_next) step();
    xs_n = 1'b0; dram_sel = 1'b1; xfer_wr = 1'b1; xfer_size = 2'b11;
    port_size = 2'b00; addr_in = 28'h0123456;
    step();
    xs_n = 1'b1; dram_sel = 1'b0;
    repeat (3) step();
    chk("R1", "ras_n low before reset", 32'(ras_n), 32'd0);
    rst = 1'b1;
    step();
    chk_idle("R1");
    rst = 1'b0;
    rise_next = 1'b1;
    step();
    step();
    chk_idle("R1");

    // transfer after reset recovery
    run_xfer(VECS[1], 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule